// File: doc/BRIEF.md
# Flash Parallel Programming Sequencer

This block sequences parallel-mode programming of a 4 KB on-chip flash code array. An external programmer selects an operation on a three-bit mode input. It presents a 12-bit address and a data byte, then strobes an active-low program pulse. The block supports these operations:

- byte program
- lock-bit program
- chip erase
- verify read
- signature read

Writes are self-timed. A ready line is low while a write or erase is in progress. Writes and erases also need a high-voltage-present flag.

The array is a register memory. Programming can only clear bits, so a byte program stores the old contents ANDed with the new data. The way back to blank bytes is a chip erase. Erase needs the program pulse held low for a set number of cycles. It then sweeps every location to FFh, one location per cycle, and clears all three lock bits.

While a byte write is in progress, a verify read of the address being written returns the complement of the new data's bit 7. A programmer can poll on this bit for completion.

Top module: `flash_prog_seq`

## Requirements
- R1: After synchronous reset, `ready` is 1, no lock bit is programmed, and with mode 3'b000 (no operation) `dout` reads FFh.
- R2: Byte program (mode 3'b001, `hv_ok`=1) starts on the clock edge that first samples `prog_n` low after it was high. `ready` is then low for exactly WRITE_CYCLES clock cycles. After that, the location holds its old value AND `din`.
- R3: While a byte write is in progress, a verify read (mode 3'b010) of that write's address returns, in `dout[7]`, the inverse of bit 7 of the data being written.
- R4: A byte program or chip erase requested with `hv_ok`=0 is ignored: `ready` stays 1 and the array is unchanged.
- R5: A program-pulse falling edge that arrives while `ready` is 0 is ignored. The write in progress completes unchanged.
- R6: Chip erase (mode 3'b100) takes effect only if `prog_n` stays low on ERASE_HOLD further clock edges after the edge that detected the fall. If it rises earlier, the erase is abandoned and nothing changes.
- R7: Once accepted, chip erase holds `ready` low for exactly 4096 cycles. It then leaves every location at FFh and all lock bits unprogrammed.
- R8: Lock program (mode 3'b011) sets the lock bit chosen by `addr[1:0]` (values 0, 1 and 2). It is self-timed like a byte program and needs no `hv_ok`. With `addr[1:0]`=3 it is ignored and `ready` stays 1.
- R9: A verify read returns the stored byte while no lock bit is programmed. Once any lock bit is programmed it returns FFh.
- R10: A signature read (mode 3'b101) returns:
  - 1Eh at address 030h;
  - 51h at address 031h;
  - at address 032h, FFh when HIGH_VPP=1 or 05h when HIGH_VPP=0;
  - 00h at any other address.
- R11: A mode with no read function (3'b000, 3'b001, 3'b011, 3'b100, 3'b110, 3'b111) drives `dout` to FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Array, lock-select or signature address |
| din | input | 8 | Byte to program |
| mode | input | 3 | Operation select |
| hv_ok | input | 1 | High programming voltage present |
| prog_n | input | 1 | Active-low program pulse |
| dout | output | 8 | Verify, polling or signature data |
| ready | output | 1 | 1 when idle, 0 during a write or erase sweep |

## Verification
The assertions assume that `prog_n` is a clean, synchronous level that stays high for at least one clock between pulses. They also assume that `mode` and `addr` are valid on the edge that detects a pulse. The bench changes every input only on falling clock edges. Each byte or lock pulse lasts exactly one cycle, and erase holds are counted in whole cycles. The bench deliberately sends pulses during busy periods and with the high-voltage flag low, so that the rejection paths are exercised inside these assumptions.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'b000,
        CMD_BYTE   = 3'b001,
        CMD_VERIFY = 3'b010,
        CMD_LOCK   = 3'b011,
        CMD_ERASE  = 3'b100,
        CMD_SIG    = 3'b101
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_LOCKW,
        ST_EHOLD,
        ST_SWEEP
    } state_e;

    localparam int          LOCK_BITS = 3;
    localparam logic [7:0]  BLANK     = 8'hFF;
    localparam int          SIG_BASE  = 'h30;

    typedef struct packed {
        logic [7:0] data;
        logic [1:0] lock_sel;
    } pend_t;

    function automatic logic [7:0] sig_byte(input logic [1:0] idx, input logic hi_vpp);
        case (idx)
            2'd0:    return 8'h1E;
            2'd1:    return 8'h51;
            2'd2:    return hi_vpp ? 8'hFF : 8'h05;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/fps_array.sv
module fps_array #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [7:0]        rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [7:0]        rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
    import fps_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int WRITE_CYCLES = 1000,
    parameter int ERASE_HOLD   = 2000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [7:0]           din,
    input  logic [2:0]           mode,
    input  logic                 hv_ok,
    input  logic                 prog_n,
    input  logic [7:0]           old_byte,
    output logic                 we,
    output logic [ADDR_W-1:0]    waddr,
    output logic [7:0]           wdata,
    output logic                 ready,
    output logic [LOCK_BITS-1:0] lock_q,
    output logic                 poll_act,
    output logic [ADDR_W-1:0]    pend_addr,
    output logic [7:0]           pend_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(DEPTH + WRITE_CYCLES + ERASE_HOLD + 1);
    localparam logic [CNT_W-1:0] W_LAST = CNT_W'(WRITE_CYCLES - 1);
    localparam logic [CNT_W-1:0] H_LAST = CNT_W'(ERASE_HOLD - 1);
    localparam logic [CNT_W-1:0] S_LAST = CNT_W'(DEPTH - 1);

    state_e           state;
    logic [CNT_W-1:0] cnt;
    logic             prog_d;
    logic             prog_fall;
    pend_t            pend;
    cmd_e             cmd;
    logic             idle;
    logic             acc_byte, acc_lock, acc_erase;

    assign cmd       = cmd_e'(mode);
    assign prog_fall = prog_d & ~prog_n;
    assign idle      = (state == ST_IDLE);
    assign acc_byte  = prog_fall && idle && cmd == CMD_BYTE && hv_ok;
    assign acc_lock  = prog_fall && idle && cmd == CMD_LOCK && addr[1:0] != 2'b11;
    assign acc_erase = prog_fall && idle && cmd == CMD_ERASE && hv_ok;

    always_ff @(posedge clk) begin
        if (rst) prog_d <= 1'b1;
        else     prog_d <= prog_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            lock_q    <= '0;
            pend_addr <= '0;
            pend      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (acc_byte) begin
                        state     <= ST_WRITE;
                        cnt       <= W_LAST;
                        pend_addr <= addr;
                        pend.data <= din;
                    end else if (acc_lock) begin
                        state         <= ST_LOCKW;
                        cnt           <= W_LAST;
                        pend.lock_sel <= addr[1:0];
                    end else if (acc_erase) begin
                        state <= ST_EHOLD;
                        cnt   <= '0;
                    end
                end
                ST_WRITE: begin
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_LOCKW: begin
                    if (cnt == '0) begin
                        lock_q[pend.lock_sel] <= 1'b1;
                        state                 <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_EHOLD: begin
                    if (prog_n) begin
                        state <= ST_IDLE;
                    end else if (cnt == H_LAST) begin
                        state <= ST_SWEEP;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SWEEP: begin
                    if (cnt == S_LAST) begin
                        state  <= ST_IDLE;
                        lock_q <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign we        = (state == ST_WRITE && cnt == '0) || state == ST_SWEEP;
    assign waddr     = (state == ST_SWEEP) ? cnt[ADDR_W-1:0] : pend_addr;
    assign wdata     = (state == ST_SWEEP) ? BLANK : (old_byte & pend.data);
    assign ready     = idle || state == ST_EHOLD;
    assign poll_act  = (state == ST_WRITE);
    assign pend_data = pend.data;

    // R4
    hv_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_fall && idle && !hv_ok && (cmd == CMD_BYTE || cmd == CMD_ERASE)) |=> ready);

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE && cnt != '0) |=> (state == ST_WRITE && $stable(pend_addr) && $stable(pend_data)));

    // R2
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> ($past(prog_fall) || $past(state == ST_EHOLD)));

    // R2
    write_end_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE && cnt == '0) |=> ready);

    // R6
    erase_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EHOLD && prog_n) |=> (state == ST_IDLE));

    // R7
    erase_lock_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SWEEP && cnt == S_LAST) |=> (lock_q == '0 && ready));
endmodule

// File: rtl/fps_readout.sv
module fps_readout
    import fps_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter bit HIGH_VPP = 1'b1
) (
    input  logic [2:0]           mode,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [7:0]           rd_data,
    input  logic [LOCK_BITS-1:0] lock_q,
    input  logic                 poll_act,
    input  logic [ADDR_W-1:0]    pend_addr,
    input  logic [7:0]           pend_data,
    output logic [7:0]           dout
);
    localparam logic [ADDR_W-1:0] SIG_LO = ADDR_W'(SIG_BASE);
    localparam logic [ADDR_W-1:0] SIG_HI = ADDR_W'(SIG_BASE + 2);

    cmd_e              cmd;
    logic              polling;
    logic [ADDR_W-1:0] sig_off;

    assign cmd     = cmd_e'(mode);
    assign polling = poll_act && addr == pend_addr;
    assign sig_off = addr - SIG_LO;

    always_comb begin
        case (cmd)
            CMD_VERIFY: begin
                if (polling)      dout = {~pend_data[7], rd_data[6:0]};
                else if (|lock_q) dout = BLANK;
                else              dout = rd_data;
            end
            CMD_SIG: begin
                if (addr >= SIG_LO && addr <= SIG_HI) dout = sig_byte(sig_off[1:0], HIGH_VPP);
                else                                  dout = 8'h00;
            end
            default: dout = BLANK;
        endcase
    end

    always_comb begin
        // R10
        if (cmd == CMD_SIG && addr == SIG_LO)
            sig_mfr_chk: assert (dout == 8'h1E);
        // R9
        if (cmd == CMD_VERIFY && |lock_q && !polling)
            lock_hide_chk: assert (dout == BLANK);
    end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import fps_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int WRITE_CYCLES = 1000,
    parameter int ERASE_HOLD   = 2000,
    parameter bit HIGH_VPP     = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic [2:0]        mode,
    input  logic              hv_ok,
    input  logic              prog_n,
    output logic [7:0]        dout,
    output logic              ready
);
    logic                 we;
    logic [ADDR_W-1:0]    waddr;
    logic [7:0]           wdata;
    logic [7:0]           rd_data;
    logic [7:0]           old_byte;
    logic [LOCK_BITS-1:0] lock_q;
    logic                 poll_act;
    logic [ADDR_W-1:0]    pend_addr;
    logic [7:0]           pend_data;

    fps_ctrl #(
        .ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES), .ERASE_HOLD(ERASE_HOLD)
    ) u_ctrl (
        .clk(clk), .rst(rst), .addr(addr), .din(din), .mode(mode),
        .hv_ok(hv_ok), .prog_n(prog_n), .old_byte(old_byte),
        .we(we), .waddr(waddr), .wdata(wdata), .ready(ready),
        .lock_q(lock_q), .poll_act(poll_act),
        .pend_addr(pend_addr), .pend_data(pend_data)
    );

    fps_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr_a(addr), .rdata_a(rd_data),
        .raddr_b(pend_addr), .rdata_b(old_byte)
    );

    fps_readout #(.ADDR_W(ADDR_W), .HIGH_VPP(HIGH_VPP)) u_readout (
        .mode(mode), .addr(addr), .rd_data(rd_data), .lock_q(lock_q),
        .poll_act(poll_act), .pend_addr(pend_addr), .pend_data(pend_data),
        .dout(dout)
    );
endmodule

// File: tb/test_flash_prog_seq.sv
module test_flash_prog_seq;
    localparam int W  = 20;
    localparam int EH = 50;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] addr;
    logic [7:0]  din;
    logic [2:0]  mode;
    logic        hv_ok;
    logic        prog_n;
    logic [7:0]  dout;
    logic        ready;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    flash_prog_seq #(.ADDR_W(12), .WRITE_CYCLES(W), .ERASE_HOLD(EH), .HIGH_VPP(1'b1)) i_flash_prog_seq (
        .clk(clk), .rst(rst), .addr(addr), .din(din), .mode(mode),
        .hv_ok(hv_ok), .prog_n(prog_n), .dout(dout), .ready(ready)
    );

    task automatic chk(input int act, input int exp, input string msg);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
        end
    endtask

    task automatic pulse(input logic [2:0] m, input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        mode = m; addr = a; din = d; prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic rd(input logic [2:0] m, input logic [11:0] a, output logic [7:0] v);
        @(negedge clk);
        mode = m; addr = a;
        #1 v = dout;
    endtask

    task automatic erase_hold(input int hold, output int busy);
        busy = 0;
        @(negedge clk);
        mode = 3'b100; prog_n = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (i == hold) prog_n = 1'b1;
            if (!ready) busy++;
            if (i > hold && ready) break;
        end
    endtask

    task automatic t_reset();
        chk(ready, 1, "R1 ready after reset");
        mode = 3'b000; #1;
        chk(dout, 8'hFF, "R11 idle mode dout");
        mode = 3'b110; #1;
        chk(dout, 8'hFF, "R11 unused mode dout");
    endtask

    task automatic t_erase();
        int b; logic [7:0] v;
        erase_hold(EH + 5, b);
        chk(b, 4096, "R7 erase sweep length");
        rd(3'b010, 12'h000, v); chk(v, 8'hFF, "R7 erased 000");
        rd(3'b010, 12'hFFF, v); chk(v, 8'hFF, "R7 erased FFF");
        rd(3'b010, 12'h123, v); chk(v, 8'hFF, "R7 erased 123");
        pulse(3'b001, 12'h010, 8'h5A); wait_ready(b);
        erase_hold(EH / 2, b);
        chk(b, 0, "R6 short erase pulse no busy");
        rd(3'b010, 12'h010, v); chk(v, 8'h5A, "R6 short erase keeps data");
    endtask

    task automatic t_byte();
        int n; logic [7:0] v;
        pulse(3'b001, 12'h100, 8'h3C);
        wait_ready(n);
        chk(n, W, "R2 busy cycles");
        rd(3'b010, 12'h100, v); chk(v, 8'h3C, "R2 programmed byte");
        pulse(3'b001, 12'h100, 8'hF0);
        wait_ready(n);
        rd(3'b010, 12'h100, v); chk(v, 8'h30, "R2 AND with old value");
    endtask

    task automatic t_poll();
        int n; logic [7:0] v;
        pulse(3'b001, 12'h200, 8'hA5);
        mode = 3'b010; addr = 12'h200; #1;
        chk(dout[7], 0, "R3 polling bit7 of A5");
        wait_ready(n);
        rd(3'b010, 12'h200, v); chk(v, 8'hA5, "R3 byte after polling");
        pulse(3'b001, 12'h201, 8'h15);
        mode = 3'b010; addr = 12'h201; #1;
        chk(dout[7], 1, "R3 polling bit7 of 15");
        wait_ready(n);
    endtask

    task automatic t_hv();
        int b; logic [7:0] v;
        hv_ok = 1'b0;
        pulse(3'b001, 12'h300, 8'h00);
        chk(ready, 1, "R4 no busy without hv");
        rd(3'b010, 12'h300, v); chk(v, 8'hFF, "R4 byte unchanged without hv");
        erase_hold(EH + 5, b);
        chk(b, 0, "R4 erase ignored without hv");
        rd(3'b010, 12'h100, v); chk(v, 8'h30, "R4 data kept without hv");
        hv_ok = 1'b1;
    endtask

    task automatic t_busy();
        int n; logic [7:0] v;
        pulse(3'b001, 12'h400, 8'h11);
        repeat (3) @(negedge clk);
        pulse(3'b001, 12'h401, 8'h00);
        wait_ready(n);
        rd(3'b010, 12'h401, v); chk(v, 8'hFF, "R5 pulse while busy ignored");
        rd(3'b010, 12'h400, v); chk(v, 8'h11, "R5 first write intact");
    endtask

    task automatic t_lock();
        int n; logic [7:0] v;
        rd(3'b010, 12'h100, v); chk(v, 8'h30, "R9 verify unlocked");
        pulse(3'b011, 12'h003, 8'h00);
        chk(ready, 1, "R8 lock select 3 ignored");
        rd(3'b010, 12'h100, v); chk(v, 8'h30, "R8 still unlocked");
        hv_ok = 1'b0;
        pulse(3'b011, 12'h001, 8'h00);
        wait_ready(n);
        chk(n, W, "R8 lock write busy cycles");
        hv_ok = 1'b1;
        rd(3'b010, 12'h100, v); chk(v, 8'hFF, "R9 verify hidden when locked");
        rd(3'b101, 12'h030, v); chk(v, 8'h1E, "R10 signature while locked");
        erase_hold(EH + 2, n);
        pulse(3'b001, 12'h100, 8'h77); wait_ready(n);
        rd(3'b010, 12'h100, v); chk(v, 8'h77, "R7 locks cleared by erase");
    endtask

    task automatic t_sig();
        logic [7:0] v;
        rd(3'b101, 12'h030, v); chk(v, 8'h1E, "R10 sig 030");
        rd(3'b101, 12'h031, v); chk(v, 8'h51, "R10 sig 031");
        rd(3'b101, 12'h032, v); chk(v, 8'hFF, "R10 sig 032 high vpp");
        rd(3'b101, 12'h033, v); chk(v, 8'h00, "R10 sig 033");
        rd(3'b101, 12'h02F, v); chk(v, 8'h00, "R10 sig 02F");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; addr = '0; din = '0; mode = 3'b000; hv_ok = 1'b1; prog_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_erase();
        t_byte();
        t_poll();
        t_hv();
        t_busy();
        t_lock();
        t_sig();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule